// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block is the exception control unit of a small 32-bit RISC core. Each cycle it looks at the exception requests raised by the instruction in flight (data bus error, divide by zero, system call, breakpoint) and at the pending, masked external interrupt lines. When one of them is taken, it redirects fetch to a handler vector and issues a register-file write that saves the faulting PC in a link register. It also pushes the global interrupt enable onto a one-level save stack.

The block holds five control registers: interrupt enable, interrupt mask, interrupt pending, exception base and debug base. The core reads and writes them through a simple select/data port. A register-indirect branch through register 30 or 31 is reported to the block, which then restores the saved enable bit. The block performs no arithmetic on data, owns no general registers, and only requests writes that the core's register file carries out.

After reset the block redirects once to the exception base with interrupts disabled.

Top module: `exc_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after its release, `redirect` is 1 and `vector` equals the exception-base reset value, with no register write requested. From the first clock edge after release, `redirect` is 0 when nothing is requested. Enable, mask and pending reset to 0, and the two bases reset to their parameter values.
- R2: The handler address is the selected base plus the cause number times 32. The cause numbers are: breakpoint 1, data bus error 4, divide by zero 5, interrupt 6, system call 7.
- R3: A taken breakpoint selects the debug base and requests a write of `cur_pc` to register 31. At the following edge the enable register becomes {old bit 0, 0, 0}.
- R4: Every other taken exception selects the exception base and requests a write of `cur_pc` to register 30. At the following edge the enable register becomes {0, old bit 0, 0}.
- R5: When several requests arrive in one cycle, the priority from highest is data bus error, divide by zero, system call, breakpoint, interrupt.
- R6: An interrupt is taken only when enable bit 0 is 1, the AND of pending and mask is nonzero, and no instruction exception is requested.
- R7: With `br_valid` high and no exception taken, a branch through register 30 sets the enable register to {0, 0, old bit 1`}`, and one through register 31 sets it to {0, 0, old bit 2}. A branch through any other register leaves it unchanged.
- R8: A write to pending clears each bit written as 1 and keeps each bit written as 0. A bit raised on `irq_in` in the same cycle as its clear ends up set.
- R9: CSR selects are: 0 enable (3 bits), 1 mask, 2 pending, 3 exception base, 4 debug base. Writes to selects 0, 1, 3 and 4 replace the value. `csr_rdata` returns the selected register zero-extended, and returns 0 for selects 5 to 7.
- R10: In a cycle where an exception or interrupt is taken, the CSR write and the branch-return restore of that cycle are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | XLEN | PC of the instruction in flight |
| req_dbe | input | 1 | Data bus error (unmapped or misaligned access) |
| req_dbz | input | 1 | Divide or modulo with zero divisor |
| req_scall | input | 1 | System call |
| req_brk | input | 1 | Breakpoint |
| irq_in | input | NIRQ | Hardware set of pending bits |
| br_valid | input | 1 | Register-indirect branch executes |
| br_reg | input | 5 | Source register index of that branch |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 3 | CSR select |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Selected CSR value |
| redirect | output | 1 | Fetch must go to `vector` |
| vector | output | XLEN | Handler address |
| gpr_we | output | 1 | Link register write request |
| gpr_waddr | output | 5 | Link register index (30 or 31) |
| gpr_wdata | output | XLEN | Saved PC |

## Verification
The bench builds the block with four interrupt lines, an exception-base reset value of 0x100 and a debug-base reset value of 0x200. With these values the reset vector differs from any programmed base. Four lines are enough to keep a set pending bit apart from a cleared one. The bench programs the bases to 0x1000 and 0x2000 so that every cause number shows up as a distinct 32-byte slot in the vector.

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
  parameter int XLEN = 32,
  parameter int NIRQ = 8,
  parameter logic [XLEN-1:0] EBA_RST = '0,
  parameter logic [XLEN-1:0] DEBA_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            req_dbe,
  input  logic            req_dbz,
  input  logic            req_scall,
  input  logic            req_brk,
  input  logic [NIRQ-1:0] irq_in,
  input  logic            br_valid,
  input  logic [4:0]      br_reg,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            redirect,
  output logic [XLEN-1:0] vector,
  output logic            gpr_we,
  output logic [4:0]      gpr_waddr,
  output logic [XLEN-1:0] gpr_wdata
);
  localparam logic [2:0] CAUSE_BRK  = 3'd1;
  localparam logic [2:0] CAUSE_DBE  = 3'd4;
  localparam logic [2:0] CAUSE_DBZ  = 3'd5;
  localparam logic [2:0] CAUSE_IRQ  = 3'd6;
  localparam logic [2:0] CAUSE_SC   = 3'd7;
  localparam int SLOT_SHIFT = 5;
  localparam logic [4:0] LINK_EXC = 5'd30;
  localparam logic [4:0] LINK_DBG = 5'd31;
  localparam logic [2:0] SEL_IE = 3'd0, SEL_IM = 3'd1, SEL_IP = 3'd2,
                         SEL_EB = 3'd3, SEL_DB = 3'd4;

  logic            boot;
  logic [2:0]      ie;
  logic [NIRQ-1:0] im, ip;
  logic [XLEN-1:0] eba, deba;

  logic any_req, irq_hit, exc, is_brk, csr_ok;
  logic [2:0] cause;
  logic [NIRQ-1:0] ip_clr;

  assign any_req = req_dbe | req_dbz | req_scall | req_brk;
  assign irq_hit = ie[0] & |(ip & im);
  assign exc     = ~boot & (any_req | irq_hit);
  assign is_brk  = ~req_dbe & ~req_dbz & ~req_scall & req_brk;
  assign csr_ok  = csr_we & ~exc;

  always_comb begin
    if (req_dbe)        cause = CAUSE_DBE;
    else if (req_dbz)   cause = CAUSE_DBZ;
    else if (req_scall) cause = CAUSE_SC;
    else if (req_brk)   cause = CAUSE_BRK;
    else                cause = CAUSE_IRQ;
  end

  assign redirect  = boot | exc;
  assign vector    = boot ? eba :
                     ((is_brk ? deba : eba) + (XLEN'(cause) << SLOT_SHIFT));
  assign gpr_we    = exc;
  assign gpr_waddr = is_brk ? LINK_DBG : LINK_EXC;
  assign gpr_wdata = cur_pc;

  assign ip_clr = (csr_ok && csr_sel == SEL_IP) ? csr_wdata[NIRQ-1:0] : '0;

  always_comb begin
    case (csr_sel)
      SEL_IE:  csr_rdata = XLEN'(ie);
      SEL_IM:  csr_rdata = XLEN'(im);
      SEL_IP:  csr_rdata = XLEN'(ip);
      SEL_EB:  csr_rdata = eba;
      SEL_DB:  csr_rdata = deba;
      default: csr_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot <= 1'b1;
      ie   <= '0;
      im   <= '0;
      ip   <= '0;
      eba  <= EBA_RST;
      deba <= DEBA_RST;
    end else begin
      boot <= 1'b0;
      ip   <= (ip & ~ip_clr) | irq_in;
      if (exc)
        ie <= is_brk ? {ie[0], 2'b00} : {1'b0, ie[0], 1'b0};
      else if (br_valid && br_reg == LINK_EXC)
        ie <= {2'b00, ie[1]};
      else if (br_valid && br_reg == LINK_DBG)
        ie <= {2'b00, ie[2]};
      else if (csr_ok && csr_sel == SEL_IE)
        ie <= csr_wdata[2:0];
      if (csr_ok && csr_sel == SEL_IM) im   <= csr_wdata[NIRQ-1:0];
      if (csr_ok && csr_sel == SEL_EB) eba  <= csr_wdata;
      if (csr_ok && csr_sel == SEL_DB) deba <= csr_wdata;
    end
  end

  assert_irq_needs_ie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot && !ie[0] && !any_req) |-> !redirect);

  assert_ie_push_exc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && !is_brk) |=> ie == {1'b0, $past(ie[0]), 1'b0});

  assert_ie_push_brk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && is_brk) |=> ie == {$past(ie[0]), 2'b00});

  assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_in) |=> (ip & $past(irq_in)) == $past(irq_in));

  assert_dbe_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dbe && !boot) |-> (vector == eba + XLEN'(4 * 32) && gpr_waddr == LINK_EXC));

  assert_exc_drops_csr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc && csr_we && csr_sel == SEL_EB) |=> $stable(eba));

  assert_return_r30_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_reg == LINK_EXC && !exc) |=> ie == {2'b00, $past(ie[1])});
endmodule

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  localparam int XLEN = 32;
  localparam int NIRQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [XLEN-1:0] cur_pc = '0;
  logic req_dbe = 0, req_dbz = 0, req_scall = 0, req_brk = 0;
  logic [NIRQ-1:0] irq_in = '0;
  logic br_valid = 0;
  logic [4:0] br_reg = '0;
  logic csr_we = 0;
  logic [2:0] csr_sel = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata, vector, gpr_wdata;
  logic redirect, gpr_we;
  logic [4:0] gpr_waddr;

  int nvec = 0, nbad = 0;

  always #5 clk = ~clk;

  exc_ctrl #(.XLEN(XLEN), .NIRQ(NIRQ), .EBA_RST(32'h100), .DEBA_RST(32'h200)) i_exc_ctrl (
    .clk, .rst_n, .cur_pc, .req_dbe, .req_dbz, .req_scall, .req_brk, .irq_in,
    .br_valid, .br_reg, .csr_we, .csr_sel, .csr_wdata, .csr_rdata,
    .redirect, .vector, .gpr_we, .gpr_waddr, .gpr_wdata);

  // {dbe,dbz,scall,brk}, expected vector, link index, enable after
  localparam logic [43:0] VECS [8] = '{
    {4'b1000, 32'h0000_1080, 5'd30, 3'b010},
    {4'b0100, 32'h0000_10A0, 5'd30, 3'b010},
    {4'b0010, 32'h0000_10E0, 5'd30, 3'b010},
    {4'b0001, 32'h0000_2020, 5'd31, 3'b100},
    {4'b1100, 32'h0000_1080, 5'd30, 3'b010},
    {4'b0110, 32'h0000_10A0, 5'd30, 3'b010},
    {4'b1001, 32'h0000_1080, 5'd30, 3'b010},
    {4'b0101, 32'h0000_10A0, 5'd30, 3'b010}
  };

  task automatic chk(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] sel, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [XLEN-1:0] exp, input string tag);
    @(negedge clk);
    csr_sel = sel;
    #1 chk(tag, csr_rdata, exp);
  endtask

  task automatic branch(input logic [4:0] r);
    @(negedge clk);
    br_valid = 1; br_reg = r;
    @(negedge clk);
    br_valid = 0;
  endtask

  initial begin
    #1_000_000;
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 boot redirect", XLEN'(redirect), 1);
    chk("R1 boot vector", vector, 32'h100);
    chk("R1 boot no write", XLEN'(gpr_we), 0);
    chk("R1 enable reset", csr_rdata, 0);
    @(posedge clk); #1;
    chk("R1 redirect drops", XLEN'(redirect), 0);
    rd(3'd4, 32'h200, "R1 debug base reset");
    rd(3'd2, 0, "R1 pending reset");

    csr_wr(3'd3, 32'h1000);
    csr_wr(3'd4, 32'h2000);
    rd(3'd3, 32'h1000, "R9 base write");
    rd(3'd7, 0, "R9 unused select");

    foreach (VECS[i]) begin
      csr_wr(3'd0, 1);
      @(negedge clk);
      {req_dbe, req_dbz, req_scall, req_brk} = VECS[i][43:40];
      cur_pc = 32'h400 + 32'(i) * 4;
      #3;
      chk("R2 R5 vector", vector, VECS[i][39:8]);
      chk("R3 R4 link index", XLEN'(gpr_waddr), XLEN'(VECS[i][7:3]));
      chk("R3 R4 saved pc", gpr_wdata, 32'h400 + 32'(i) * 4);
      chk("R3 R4 write req", XLEN'(gpr_we), 1);
      @(negedge clk);
      {req_dbe, req_dbz, req_scall, req_brk} = 4'b0;
      csr_sel = 3'd0;
      #1 chk("R3 R4 enable push", csr_rdata, XLEN'(VECS[i][2:0]));
    end

    // R6: pending but masked
    @(negedge clk); irq_in = 4'b0100;
    @(negedge clk); irq_in = 0;
    csr_wr(3'd0, 1);
    #1 chk("R6 masked no take", XLEN'(redirect), 0);
    rd(3'd2, 4, "R8 hw set pending");
    // R6: enable clear, mask set
    csr_wr(3'd0, 0);
    csr_wr(3'd1, 4);
    #1 chk("R6 disabled no take", XLEN'(redirect), 0);
    // enable -> take
    @(negedge clk); csr_we = 1; csr_sel = 3'd0; csr_wdata = 1;
    @(negedge clk); csr_we = 0; cur_pc = 32'h880;
    #1;
    chk("R6 irq taken", XLEN'(redirect), 1);
    chk("R2 irq vector", vector, 32'h10C0);
    chk("R4 irq link", XLEN'(gpr_waddr), 30);
    @(negedge clk); csr_sel = 3'd0;
    #1 chk("R4 irq enable push", csr_rdata, 2);
    chk("R6 no retake", XLEN'(redirect), 0);
    // clear pending (w1c), keep other bits
    @(negedge clk); irq_in = 4'b0001;
    @(negedge clk); irq_in = 0;
    csr_wr(3'd2, 4);
    rd(3'd2, 1, "R8 w1c clears only ones");
    csr_wr(3'd2, 1);
    branch(5'd30);
    csr_sel = 3'd0;
    #1 chk("R7 return r30", csr_rdata, 1);
    chk("R7 no pending no take", XLEN'(redirect), 0);
    csr_wr(3'd0, 3'b100);
    branch(5'd31);
    #1 chk("R7 return r31", csr_rdata, 1);
    csr_wr(3'd0, 3'b110);
    branch(5'd7);
    #1 chk("R7 other reg unchanged", csr_rdata, 6);

    // R8: hw set and sw clear same cycle (IE=0 so no take)
    csr_wr(3'd0, 0);
    @(negedge clk); irq_in = 4'b0100; csr_we = 1; csr_sel = 3'd2; csr_wdata = 4'b0100;
    @(negedge clk); irq_in = 0; csr_we = 0;
    #1 chk("R8 set wins", csr_rdata, 4);
    csr_wr(3'd2, 4'hF);
    rd(3'd2, 0, "R8 cleared");

    // R10: exception discards CSR write
    csr_wr(3'd0, 1);
    @(negedge clk); req_dbz = 1; csr_we = 1; csr_sel = 3'd3; csr_wdata = 32'hDEAD_0000;
    @(negedge clk); req_dbz = 0; csr_we = 0;
    rd(3'd3, 32'h1000, "R10 base write dropped");
    // R10: exception discards branch restore
    csr_wr(3'd0, 1);
    @(negedge clk); req_scall = 1; br_valid = 1; br_reg = 5'd30;
    @(negedge clk); req_scall = 0; br_valid = 0;
    rd(3'd0, 2, "R10 restore dropped");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule